// File: doc/BRIEF.md
# Four-Tap One-Bit Bitstream Delay Line

This block delays a one-bit pulse-density stream through a long ring of storage. It brings out four delayed copies, spaced at equal intervals along the ring. The stream moves forward one position only on clock cycles where the shift enable is high. An external variable-rate strobe drives that enable, so the delay in seconds is the segment depth divided by the strobe rate. At the default sizes a segment holds 12,288 bits. Strobe rates from 61,440 Hz up to 245,760 Hz therefore give between 200 ms and 50 ms of delay per segment. The deepest tap reaches four segments, or 49,152 bits.

The storage is a single ring RAM. One write pointer advances on each shift. Tap k reads the slot k segments behind that pointer. A two-state controller tracks whether the ring has been filled since reset. In state FILLING every tap reads as zero. On the shift that writes the last slot of the first lap, the controller takes the transition FILLING to STREAMING. STREAMING is left only by reset, which returns the controller to FILLING. A bypass select lets the modulator stream be observed without the delay. A separate dry output always carries the most recently shifted input bit.

Top module: `bitstream_delay_top`

## Requirements
- R1: While rst_n is low, all four tap outputs and dry_out are 0.
- R2: On a cycle with shift_en low, no output changes, and that cycle does not count as a shift.
- R3: Number the accepted shifts since reset from 0, and let shift n carry din_n. Once the ring has been filled, taps[j] after shift n equals din_(n−(j+1)·12288) for j = 0, 1, 2, where taps[0] is the shortest delay.
- R4: The taps are all 0 after each of the first 49,152 shifts following reset, when bypass_sel is low. The first non-zero-capable tap value appears after shift 49,152.
- R5: taps[3] after shift n equals din_(n−49152), which means the write pointer wraps around the full ring. This holds over repeated laps.
- R6: On a shift with bypass_sel high, all four taps take that shift's din. This applies while FILLING as well as while STREAMING.
- R7: After every shift, dry_out equals that shift's din, whatever the mode.
- R8: Bits shifted in while bypass_sel is high are still stored in the ring. They later appear at each tap at their normal delay.
- R9: A reset issued while STREAMING returns the block to FILLING. The taps read 0 for the next 49,152 shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift strobe from the variable-rate source |
| bypass_sel | input | 1 | Route din to all taps instead of the ring |
| din | input | 1 | Serial bitstream input |
| taps | output | 4 | Delayed bits; bit 0 is one segment, bit 3 is four segments |
| dry_out | output | 1 | Last shifted input bit |

## Verification
A write pointer that skips or repeats a slot shows as a tap mismatch at exactly one segment after the fault. The deepest tap exposes it only after a full ring lap of 49,152 shifts. A controller that enters STREAMING early lets uninitialised ring contents reach the taps before shift 49,152. A controller that enters late holds the taps at zero past that shift. Either fault is visible on the first shift after the correct boundary. A bypass path that blocks writes corrupts the taps one segment after the bypass window.

// File: rtl/bdl_pkg.sv
`timescale 1ns/1ps
package bdl_pkg;

    // Fill tracking for the ring
    typedef enum logic {
        FILLING   = 1'b0,
        STREAMING = 1'b1
    } ring_state_t;

endpackage

// File: rtl/bdl_fill_ctrl.sv
`timescale 1ns/1ps
module bdl_fill_ctrl
    import bdl_pkg::*;
#(
    parameter int DEPTH = 49152,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    output logic [AW-1:0] wr_ptr,
    output logic          live
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    ring_state_t   state_q, state_d;
    logic [AW-1:0] ptr_d;
    logic          at_last;

    assign at_last = (wr_ptr == LAST_SLOT);

    // State register and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILLING;
            wr_ptr  <= '0;
        end else begin
            state_q <= state_d;
            wr_ptr  <= ptr_d;
        end
    end

    // Next state, next pointer and outputs
    always_comb begin
        state_d = state_q;
        ptr_d   = wr_ptr;
        live    = 1'b0;
        if (shift_en) begin
            ptr_d = at_last ? '0 : wr_ptr + 1'b1;
        end
        unique case (state_q)
            FILLING: begin
                if (shift_en && at_last) begin
                    state_d = STREAMING;
                end
            end
            STREAMING: begin
                live = 1'b1;
            end
        endcase
    end

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= LAST_SLOT)
        else $error("write pointer outside ring");

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(wr_ptr))
        else $error("write pointer moved without shift");

    // R9
    live_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> live)
        else $error("left STREAMING without reset");

endmodule

// File: rtl/bdl_ring_ram.sv
`timescale 1ns/1ps
module bdl_ring_ram #(
    parameter int DEPTH  = 49152,
    parameter int WORD_W = 32,
    parameter int N_RD   = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = $clog2(WORD_W),
    localparam int NWORD = DEPTH / WORD_W
) (
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      wr_addr,
    input  logic               wr_bit,
    input  logic [N_RD*AW-1:0] rd_addr,
    output logic [N_RD-1:0]    rd_bit
);

    logic [WORD_W-1:0] mem [NWORD];

    // Bit-granular write; reads below see the value before this edge
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_addr[AW-1:BW]][wr_addr[BW-1:0]] <= wr_bit;
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        logic [AW-1:0] a;
        assign a         = rd_addr[g*AW +: AW];
        assign rd_bit[g] = mem[a[AW-1:BW]][a[BW-1:0]];
    end

endmodule

// File: rtl/bdl_tap_out.sv
`timescale 1ns/1ps
module bdl_tap_out #(
    parameter int N_TAPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bypass_sel,
    input  logic              din,
    input  logic              live,
    input  logic [N_TAPS-1:0] rd_bits,
    output logic [N_TAPS-1:0] taps,
    output logic              dry_out
);

    logic [N_TAPS-1:0] taps_d;

    always_comb begin
        if (bypass_sel) begin
            taps_d = {N_TAPS{din}};
        end else if (live) begin
            taps_d = rd_bits;
        end else begin
            taps_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps    <= '0;
            dry_out <= 1'b0;
        end else if (shift_en) begin
            taps    <= taps_d;
            dry_out <= din;
        end
    end

    // R2
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(taps) && $stable(dry_out)))
        else $error("outputs moved without shift");

    // R6
    bypass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && bypass_sel) |=> (taps == {N_TAPS{$past(din)}}))
        else $error("bypass did not copy input");

    // R7
    dry_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (dry_out == $past(din)))
        else $error("dry output lost input");

    // R4
    fill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !bypass_sel && !live) |=> (taps == '0))
        else $error("tap non-zero before ring filled");

endmodule

// File: rtl/bitstream_delay_top.sv
`timescale 1ns/1ps
module bitstream_delay_top #(
    parameter int SUB_BITS     = 1024,
    parameter int SUBS_PER_SEG = 12,
    parameter int N_TAPS       = 4,
    parameter int WORD_W       = 32,
    localparam int SEG         = SUB_BITS * SUBS_PER_SEG,
    localparam int TOTAL       = SEG * N_TAPS,
    localparam int AW          = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bypass_sel,
    input  logic              din,
    output logic [N_TAPS-1:0] taps,
    output logic              dry_out
);

    logic [AW-1:0]        wr_ptr;
    logic                 live;
    logic [N_TAPS*AW-1:0] rd_addr;
    logic [N_TAPS-1:0]    rd_bits;

    bdl_fill_ctrl #(
        .DEPTH    (TOTAL)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .wr_ptr   (wr_ptr),
        .live     (live)
    );

    // Tap j trails the write pointer by (j+1) segments, modulo the ring
    for (genvar j = 0; j < N_TAPS; j++) begin : g_tap_addr
        localparam int            OFF_M = ((j + 1) * SEG) % TOTAL;
        localparam logic [AW-1:0] BACK  = AW'(OFF_M);
        localparam logic [AW-1:0] WRAP  = AW'(TOTAL - OFF_M);
        assign rd_addr[j*AW +: AW] = (wr_ptr >= BACK) ? (wr_ptr - BACK)
                                                      : (wr_ptr + WRAP);
    end

    bdl_ring_ram #(
        .DEPTH   (TOTAL),
        .WORD_W  (WORD_W),
        .N_RD    (N_TAPS)
    ) u_ram (
        .clk     (clk),
        .we      (shift_en),
        .wr_addr (wr_ptr),
        .wr_bit  (din),
        .rd_addr (rd_addr),
        .rd_bit  (rd_bits)
    );

    bdl_tap_out #(
        .N_TAPS     (N_TAPS)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .bypass_sel (bypass_sel),
        .din        (din),
        .live       (live),
        .rd_bits    (rd_bits),
        .taps       (taps),
        .dry_out    (dry_out)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (taps == '0 && dry_out == 1'b0))
        else $error("outputs not cleared in reset");

endmodule

// File: tb/sim_bitstream_delay_top.sv
`timescale 1ns/1ps
module sim_bitstream_delay_top;

    localparam int SEG   = 12288;
    localparam int TOTAL = 4 * SEG;
    localparam int BYP_A = 100;
    localparam int BYP_B = TOTAL + 5000;
    localparam int BYP_N = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_en = 1'b0;
    logic       bypass_sel = 1'b0;
    logic       din = 1'b0;
    logic [3:0] taps;
    logic       dry_out;

    int   n_checks = 0;
    int   n_errors = 0;
    int   n = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    logic [3:0] exp_taps = '0;
    logic       exp_dry = 1'b0;

    always #10 clk = ~clk;

    bitstream_delay_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .bypass_sel (bypass_sel),
        .din        (din),
        .taps       (taps),
        .dry_out    (dry_out)
    );

    function automatic logic src_bit(int idx);
        logic [31:0] h;
        h = 32'(idx) * 32'h9E3779B1;
        h = h ^ (h >> 13);
        return h[17];
    endfunction

    function automatic bit in_byp(int idx);
        return (idx >= BYP_A && idx < BYP_A + BYP_N) ||
               (idx >= BYP_B && idx < BYP_B + BYP_N);
    endfunction

    task automatic check_bit(string req, string what, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s at shift %0d: got %b expected %b", req, what, n, got, exp);
        end
    endtask

    // One clock: drive at falling edge, check shortly after rising edge
    task automatic cycle(logic en, logic byp, bit after_rst);
        logic d;
        string req;
        @(negedge clk);
        d = src_bit(n);
        shift_en   = en;
        bypass_sel = byp;
        din        = d;
        if (en) begin
            exp_dry = d;
            for (int k = 0; k < 4; k++) begin
                if (byp)             exp_taps[k] = d;
                else if (n < TOTAL)  exp_taps[k] = 1'b0;
                else                 exp_taps[k] = src_bit(n - (k + 1) * SEG);
            end
        end
        @(posedge clk);
        #2;
        for (int k = 0; k < 4; k++) begin
            if (!en)                                     req = "R2";
            else if (byp)                                req = "R6";
            else if (n < TOTAL)                          req = after_rst ? "R9" : "R4";
            else if (in_byp(n - (k + 1) * SEG))          req = "R8";
            else if (k == 3)                             req = "R5";
            else                                         req = "R3";
            check_bit(req, $sformatf("tap%0d", k), taps[k], exp_taps[k]);
        end
        check_bit(en ? "R7" : "R2", "dry", dry_out, exp_dry);
        if (en) n++;
        cyc++;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R1
        check_bit("R1", "taps", |taps, 1'b0);
        check_bit("R1", "dry", dry_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0; exp_taps = '0; exp_dry = 1'b0;
    endtask

    // Fill the ring with gaps in the strobe and a bypass window
    task automatic t_fill();
        while (n < TOTAL) begin
            cycle((cyc % 8) != 7, in_byp(n), 1'b0);
        end
    endtask

    // Stream past the wrap, with a second bypass window
    task automatic t_stream(int shifts);
        int stop;
        stop = n + shifts;
        while (n < stop) begin
            cycle((cyc % 8) != 7, in_byp(n), 1'b0);
        end
    endtask

    // R9: reset while streaming, then confirm taps read zero again
    task automatic t_mid_reset();
        @(negedge clk);
        shift_en = 1'b0;
        rst_n = 1'b0;
        #5;
        check_bit("R1", "taps", |taps, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0; exp_taps = '0; exp_dry = 1'b0;
        for (int i = 0; i < 300; i++) cycle(1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_stream(SEG + 6000);
        t_mid_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule